// File: doc/BRIEF.md
# Dual-Channel Synchronous Serial Receiver

This block takes serial words from two data lines, a primary and a secondary. Both lines share one bit strobe and one frame-sync input, and they advance in lock step. Each line feeds its own shift register. Once the programmed number of bits has arrived, the assembled word is moved into that channel's receive buffer, and the valid flag for that buffer is raised. On the primary channel only, the word can first be decoded from an 8-bit mu-law code into signed linear form.

A direction bit selects receive (0) or transmit (1). In receive mode the two transmit buffers are never drained. Host writes into them accumulate until the buffer is full. After that, any further write raises a stall output that stays high for as long as the host keeps the write request asserted. In transmit mode the receive logic ignores the bit strobe and frame-sync, and the transmit buffers can be drained one word at a time by a downstream serializer, which is outside this block. The port has no start/stop-bit framing of any kind.

Top module: `sport_rx_dual`

## Requirements
- R1: While `rst` is high, at the next clock both receive valid flags and both overflow flags are 0, both transmit levels are 0, `tx_full` is 0 and `host_stall` is 0.
- R2: With `fs_en`=1, a bit strobe that has `fsync`=1 takes the first bit of a new word. Bits arrive MSB first. After the strobe that carries the last bit, the receive buffer holds the word right-justified with zero upper bits, and its valid flag is 1.
- R3: The word length is the value of `wlen`, and every length from 3 to 32 bits is received correctly on both channels.
- R4: With `fs_en`=0, words follow each other with no gaps, starting from the first strobe after reset. No frame-sync is needed.
- R5: A frame-sync that arrives partway through a word throws away the partial bits and starts a new word with that bit.
- R6: With `exp_on`=1, the primary buffer receives the mu-law decode of the low 8 received bits. With u equal to the inverted code, the magnitude is ((2·u[3:0]+33) shifted left by u[6:4]) − 33. The result is negative when u[7]=1, and it is sign-extended to 32 bits.
- R7: The secondary buffer always receives the raw bits, whatever the value of `exp_on`.
- R8: A read pulse (`rd_a`/`rd_b`) clears that channel's valid flag and its overflow flag. A read in the same cycle as a new transfer leaves valid at 1 and overflow at 0.
- R9: If a word completes while valid is still 1 and no read is made, the overflow flag goes to 1 and the new word replaces the old one.
- R10: With `dir_tx`=1, bit strobes change neither receive buffer nor any valid flag.
- R11: With `dir_tx`=0, host writes fill a transmit buffer up to its depth (4), after which `tx_full` is 1. Pop requests have no effect.
- R12: A write to a full transmit buffer raises `host_stall` in the same cycle. The write is discarded, and the level and the contents stay unchanged.
- R13: With `dir_tx`=1, each pop removes the oldest word. `tx_head_a`/`tx_head_b` show the oldest word in the order it was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dir_tx | input | 1 | 0 = receive, 1 = transmit |
| fs_en | input | 1 | Frame-sync gates word starts |
| exp_on | input | 1 | Mu-law decode on the primary channel |
| wlen | input | 6 | Word length in bits (3..32) |
| bit_tick | input | 1 | Serial bit strobe (rising bit-clock edge) |
| fsync | input | 1 | Frame-sync, sampled with the bit |
| sd_a | input | 1 | Primary serial data |
| sd_b | input | 1 | Secondary serial data |
| rd_a | input | 1 | Host read pulse, primary buffer |
| rd_b | input | 1 | Host read pulse, secondary buffer |
| rxa_data | output | 32 | Primary receive buffer |
| rxa_valid | output | 1 | Primary buffer holds an unread word |
| rxa_ovf | output | 1 | Primary word overwritten before read |
| rxb_data | output | 32 | Secondary receive buffer |
| rxb_valid | output | 1 | Secondary buffer holds an unread word |
| rxb_ovf | output | 1 | Secondary word overwritten before read |
| tx_wr | input | 2 | Host write request per transmit buffer |
| tx_wdata | input | 32 | Host write data |
| tx_pop | input | 2 | Drain request per transmit buffer |
| tx_head_a | output | 32 | Oldest word, transmit buffer A |
| tx_head_b | output | 32 | Oldest word, transmit buffer B |
| tx_full | output | 2 | Transmit buffer full flags |
| tx_level_a | output | 3 | Fill level, transmit buffer A |
| tx_level_b | output | 3 | Fill level, transmit buffer B |
| host_stall | output | 1 | Host write held off by a full buffer |

## Verification
A wrong bit counter or a missed frame-start shows up at the very next buffer transfer: the word lands one strobe early or late, shifted by one bit, and the sweep over all lengths catches that on the first affected length. A bad decode term appears as a wrong signed value on one of the 256 mu-law codes the moment that code is received. A transmit pointer or level error shows up as a wrong head word or a wrong full flag within the four writes that fill a buffer. A leak of receive activity in transmit mode shows up as a changed receive buffer after a single word.

// File: rtl/sprx_pkg.sv
package sprx_pkg;

  // Mu-law code to signed 14-bit linear value (held in 16 bits)
  function automatic logic signed [15:0] ulaw_expand(input logic [7:0] code);
    logic [7:0]  u;
    logic [15:0] seg;
    logic [15:0] mag;
    u   = ~code;
    seg = ({11'd0, u[3:0], 1'b0} + 16'd33) << u[6:4];
    mag = seg - 16'd33;
    return u[7] ? -$signed(mag) : $signed(mag);
  endfunction

endpackage

// File: rtl/sprx_rxch.sv
module sprx_rxch
  import sprx_pkg::*;
#(
  parameter int W = 32,
  localparam int LW = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          tick,
  input  logic          fs_en,
  input  logic          fs,
  input  logic          sd,
  input  logic [LW-1:0] wlen,
  input  logic          exp_on,
  input  logic          rd,
  output logic [W-1:0]  data,
  output logic          valid,
  output logic          ovf
);

  logic [W-1:0]  sh, base, nxt_sh, word;
  logic [LW-1:0] cnt, nxt_cnt, len_c;
  logic          act, start, running, step, done;
  logic signed [15:0] lin;

  // keep the length inside the supported range
  always_comb begin
    if (wlen < LW'(3))      len_c = LW'(3);
    else if (wlen > LW'(W)) len_c = LW'(W);
    else                    len_c = wlen;
  end

  assign start   = fs_en & fs;
  assign running = start | act | ~fs_en;
  assign base    = start ? '0 : sh;
  assign nxt_sh  = {base[W-2:0], sd};
  assign nxt_cnt = start ? LW'(1) : cnt + LW'(1);
  assign step    = en & tick & running;
  assign done    = step & (nxt_cnt == len_c);

  assign lin  = ulaw_expand(nxt_sh[7:0]);
  assign word = exp_on ? W'(lin) : nxt_sh;

  // shift register and bit counter
  always_ff @(posedge clk) begin
    if (rst || !en) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
    end else if (step) begin
      if (done) begin
        sh  <= '0;
        cnt <= '0;
        act <= 1'b0;
      end else begin
        sh  <= nxt_sh;
        cnt <= nxt_cnt;
        act <= 1'b1;
      end
    end
  end

  // receive buffer with valid / overflow bookkeeping
  always_ff @(posedge clk) begin
    if (rst) begin
      data  <= '0;
      valid <= 1'b0;
      ovf   <= 1'b0;
    end else if (done) begin
      data  <= word;
      valid <= 1'b1;
      ovf   <= (ovf | valid) & ~rd;
    end else if (rd) begin
      valid <= 1'b0;
      ovf   <= 1'b0;
    end
  end

endmodule

// File: rtl/sprx_txbuf.sv
module sprx_txbuf #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int AW  = $clog2(DEPTH),
  localparam int LVW = $clog2(DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           drain,
  input  logic           wr,
  input  logic [W-1:0]   wdata,
  input  logic           pop,
  output logic [W-1:0]   head,
  output logic [LVW-1:0] level,
  output logic           full,
  output logic           stall
);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic          wr_ok, pop_ok;

  assign full   = (level == LVW'(DEPTH));
  assign wr_ok  = wr & ~full;
  assign pop_ok = pop & drain & (level != '0);
  assign stall  = wr & full;
  assign head   = mem[rp];

  always_ff @(posedge clk) begin
    if (wr_ok) mem[wp] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp    <= '0;
      rp    <= '0;
      level <= '0;
    end else begin
      if (wr_ok)  wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + AW'(1);
      if (pop_ok) rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + AW'(1);
      case ({wr_ok, pop_ok})
        2'b10:   level <= level + LVW'(1);
        2'b01:   level <= level - LVW'(1);
        default: level <= level;
      endcase
    end
  end

endmodule

// File: rtl/sport_rx_dual.sv
module sport_rx_dual #(
  parameter int W       = 32,
  parameter int TX_DEPTH = 4,
  localparam int LW  = $clog2(W + 1),
  localparam int LVW = $clog2(TX_DEPTH + 1)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dir_tx,
  input  logic           fs_en,
  input  logic           exp_on,
  input  logic [LW-1:0]  wlen,
  input  logic           bit_tick,
  input  logic           fsync,
  input  logic           sd_a,
  input  logic           sd_b,
  input  logic           rd_a,
  input  logic           rd_b,
  output logic [W-1:0]   rxa_data,
  output logic           rxa_valid,
  output logic           rxa_ovf,
  output logic [W-1:0]   rxb_data,
  output logic           rxb_valid,
  output logic           rxb_ovf,
  input  logic [1:0]     tx_wr,
  input  logic [W-1:0]   tx_wdata,
  input  logic [1:0]     tx_pop,
  output logic [W-1:0]   tx_head_a,
  output logic [W-1:0]   tx_head_b,
  output logic [1:0]     tx_full,
  output logic [LVW-1:0] tx_level_a,
  output logic [LVW-1:0] tx_level_b,
  output logic           host_stall
);

  logic rx_on;
  assign rx_on = ~dir_tx;

  // primary channel: decode allowed
  sprx_rxch #(.W(W)) u_rx_a (
    .clk(clk), .rst(rst), .en(rx_on), .tick(bit_tick), .fs_en(fs_en),
    .fs(fsync), .sd(sd_a), .wlen(wlen), .exp_on(exp_on), .rd(rd_a),
    .data(rxa_data), .valid(rxa_valid), .ovf(rxa_ovf)
  );

  // secondary channel: always raw
  sprx_rxch #(.W(W)) u_rx_b (
    .clk(clk), .rst(rst), .en(rx_on), .tick(bit_tick), .fs_en(fs_en),
    .fs(fsync), .sd(sd_b), .wlen(wlen), .exp_on(1'b0), .rd(rd_b),
    .data(rxb_data), .valid(rxb_valid), .ovf(rxb_ovf)
  );

  logic [W-1:0]   head_w  [2];
  logic [LVW-1:0] level_w [2];
  logic [1:0]     stall_w;

  for (genvar c = 0; c < 2; c++) begin : g_tx
    sprx_txbuf #(.W(W), .DEPTH(TX_DEPTH)) u_txbuf (
      .clk(clk), .rst(rst), .drain(dir_tx), .wr(tx_wr[c]),
      .wdata(tx_wdata), .pop(tx_pop[c]), .head(head_w[c]),
      .level(level_w[c]), .full(tx_full[c]), .stall(stall_w[c])
    );
  end

  assign tx_head_a  = head_w[0];
  assign tx_head_b  = head_w[1];
  assign tx_level_a = level_w[0];
  assign tx_level_b = level_w[1];
  assign host_stall = |stall_w;

endmodule

// File: rtl/sprx_chk.sv
module sprx_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         dir_tx,
  input logic [W-1:0] rxa_data,
  input logic         rxa_valid,
  input logic         rxa_ovf,
  input logic         tx_wr0,
  input logic         tx_full0
);

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (!rxa_valid && !rxa_ovf && !tx_full0));

  // R9
  ovf_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(rxa_ovf) |-> $past(rxa_valid));

  // R10
  tx_mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    dir_tx |=> $stable(rxa_data));

  // R11
  full_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (!dir_tx && tx_full0) |=> tx_full0);

  // R11
  full_from_write_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tx_full0) |-> $past(tx_wr0));

endmodule

bind sport_rx_dual sprx_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .dir_tx(dir_tx), .rxa_data(rxa_data),
  .rxa_valid(rxa_valid), .rxa_ovf(rxa_ovf),
  .tx_wr0(tx_wr[0]), .tx_full0(tx_full[0])
);

// File: tb/tb_sport_rx_dual.sv
`timescale 1ns/1ps
module tb_sport_rx_dual;

  logic        clk = 1'b0;
  logic        rst, dir_tx, fs_en, exp_on, bit_tick, fsync, sd_a, sd_b, rd_a, rd_b;
  logic [5:0]  wlen;
  logic [31:0] rxa_data, rxb_data, tx_wdata, tx_head_a, tx_head_b;
  logic        rxa_valid, rxa_ovf, rxb_valid, rxb_ovf, host_stall;
  logic [1:0]  tx_wr, tx_pop, tx_full;
  logic [2:0]  tx_level_a, tx_level_b;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  sport_rx_dual dut (
    .clk(clk), .rst(rst), .dir_tx(dir_tx), .fs_en(fs_en), .exp_on(exp_on),
    .wlen(wlen), .bit_tick(bit_tick), .fsync(fsync), .sd_a(sd_a), .sd_b(sd_b),
    .rd_a(rd_a), .rd_b(rd_b), .rxa_data(rxa_data), .rxa_valid(rxa_valid),
    .rxa_ovf(rxa_ovf), .rxb_data(rxb_data), .rxb_valid(rxb_valid),
    .rxb_ovf(rxb_ovf), .tx_wr(tx_wr), .tx_wdata(tx_wdata), .tx_pop(tx_pop),
    .tx_head_a(tx_head_a), .tx_head_b(tx_head_b), .tx_full(tx_full),
    .tx_level_a(tx_level_a), .tx_level_b(tx_level_b), .host_stall(host_stall)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mask_of(input int len);
    return (len >= 32) ? 32'hFFFF_FFFF : ((32'd1 << len) - 32'd1);
  endfunction

  function automatic logic [31:0] ulaw_ref(input int code);
    int u, mag, v;
    u   = (~code) & 255;
    mag = (((u & 15) * 2 + 33) << ((u >> 4) & 7)) - 33;
    v   = ((u & 128) != 0) ? -mag : mag;
    return 32'(v);
  endfunction

  // send one word; rd_last pulses read on both channels with the last bit
  task automatic send(input int len, input logic [31:0] a, input logic [31:0] b,
                      input bit framed, input bit rd_last);
    for (int i = len - 1; i >= 0; i--) begin
      @(negedge clk);
      bit_tick = 1'b1;
      fsync = framed && (i == len - 1);
      sd_a  = a[i];
      sd_b  = b[i];
      rd_a  = rd_last && (i == 0);
      rd_b  = rd_last && (i == 0);
    end
    @(negedge clk);
    bit_tick = 1'b0; fsync = 1'b0; rd_a = 1'b0; rd_b = 1'b0;
  endtask

  task automatic read_both();
    @(negedge clk); rd_a = 1'b1; rd_b = 1'b1;
    @(negedge clk); rd_a = 1'b0; rd_b = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; dir_tx = 1'b0; fs_en = 1'b1; exp_on = 1'b0; bit_tick = 1'b0;
    fsync = 1'b0; sd_a = 1'b0; sd_b = 1'b0; rd_a = 1'b0; rd_b = 1'b0;
    wlen = 6'd8; tx_wr = 2'b00; tx_wdata = '0; tx_pop = 2'b00;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 valid", {30'd0, rxa_valid, rxb_valid}, 32'd0);
    chk("R1 ovf", {30'd0, rxa_ovf, rxb_ovf}, 32'd0);
    chk("R1 tx", {23'd0, tx_level_a, tx_level_b, tx_full, host_stall}, 32'd0);
    rst = 1'b0;

    // R2 R3 framed sweep over all lengths on both channels
    for (int len = 3; len <= 32; len++) begin
      logic [31:0] a, b;
      a = (32'hA5C3_9E17 * len + 32'd7) & mask_of(len);
      b = (~a) & mask_of(len);
      wlen = 6'(len);
      send(len, a, b, 1'b1, 1'b0);
      chk("R2 valid a", {31'd0, rxa_valid}, 32'd1);
      chk("R3 data a", rxa_data, a);
      chk("R3 data b", rxb_data, b);
      read_both();
      chk("R8 read clears valid", {30'd0, rxa_valid, rxb_valid}, 32'd0);
    end

    // R6 R7 every mu-law code
    wlen = 6'd8; exp_on = 1'b1;
    for (int code = 0; code < 256; code++) begin
      send(8, 32'(code), 32'(code), 1'b1, 1'b0);
      chk("R6 decode a", rxa_data, ulaw_ref(code));
      chk("R7 raw b", rxb_data, 32'(code));
      read_both();
    end
    exp_on = 1'b0;

    // R5 restart on mid-word frame-sync
    wlen = 6'd16;
    for (int i = 4; i >= 0; i--) begin
      @(negedge clk); bit_tick = 1'b1; fsync = (i == 4); sd_a = 1'b1; sd_b = 1'b1;
    end
    send(16, 32'h0000_3C5A, 32'h0000_81E7, 1'b1, 1'b0);
    chk("R5 restart a", rxa_data, 32'h0000_3C5A);
    chk("R5 restart b", rxb_data, 32'h0000_81E7);
    read_both();

    // R9 overflow then overwrite, read clears it
    send(16, 32'h0000_1111, 32'h0000_2222, 1'b1, 1'b0);
    chk("R9 no ovf yet", {31'd0, rxa_ovf}, 32'd0);
    send(16, 32'h0000_3333, 32'h0000_4444, 1'b1, 1'b0);
    chk("R9 ovf set", {30'd0, rxa_ovf, rxb_ovf}, 32'd3);
    chk("R9 overwrite", rxa_data, 32'h0000_3333);
    read_both();
    chk("R8 read clears ovf", {28'd0, rxa_ovf, rxb_ovf, rxa_valid, rxb_valid}, 32'd0);

    // R8 read in the same cycle as a transfer
    send(16, 32'h0000_5555, 32'h0000_6666, 1'b1, 1'b0);
    send(16, 32'h0000_7777, 32'h0000_8888, 1'b1, 1'b1);
    chk("R8 same-cycle valid", {30'd0, rxa_valid, rxb_valid}, 32'd3);
    chk("R8 same-cycle ovf", {30'd0, rxa_ovf, rxb_ovf}, 32'd0);
    chk("R8 same-cycle data", rxa_data, 32'h0000_7777);
    read_both();

    // R10 transmit mode ignores receive traffic
    dir_tx = 1'b1;
    send(16, 32'h0000_ABCD, 32'h0000_DCBA, 1'b1, 1'b0);
    chk("R10 valid", {30'd0, rxa_valid, rxb_valid}, 32'd0);
    chk("R10 data a", rxa_data, 32'h0000_7777);
    chk("R10 data b", rxb_data, 32'h0000_8888);
    dir_tx = 1'b0;

    // R4 unframed back-to-back words from reset
    fs_en = 1'b0; wlen = 6'd12;
    do_reset();
    for (int k = 0; k < 3; k++) begin
      logic [31:0] w;
      w = (32'h0000_0A53 + 32'(k) * 32'h0000_0317) & 32'h0000_0FFF;
      send(12, w, ~w & 32'h0000_0FFF, 1'b0, 1'b0);
      chk("R4 unframed a", rxa_data, w);
      chk("R4 unframed b", rxb_data, ~w & 32'h0000_0FFF);
      read_both();
    end
    fs_en = 1'b1;

    // R11 fill transmit buffer A in receive mode
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); tx_wr = 2'b01; tx_wdata = 32'h0000_1000 + 32'(k);
    end
    @(negedge clk); tx_wr = 2'b00;
    chk("R11 level", {29'd0, tx_level_a}, 32'd4);
    chk("R11 full", {30'd0, tx_full}, 32'd1);
    // R12 stall on write to full
    tx_wr = 2'b01; tx_wdata = 32'hDEAD_BEEF;
    #1;
    chk("R12 stall", {31'd0, host_stall}, 32'd1);
    @(negedge clk); tx_wr = 2'b00;
    #1;
    chk("R12 stall drops", {31'd0, host_stall}, 32'd0);
    chk("R12 level kept", {29'd0, tx_level_a}, 32'd4);
    chk("R12 head kept", tx_head_a, 32'h0000_1000);
    // R11 pop ignored in receive mode
    @(negedge clk); tx_pop = 2'b01;
    @(negedge clk); tx_pop = 2'b00;
    chk("R11 pop ignored", {29'd0, tx_level_a}, 32'd4);
    // R13 drain in order in transmit mode
    dir_tx = 1'b1;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R13 head order", tx_head_a, 32'h0000_1000 + 32'(k));
      tx_pop = 2'b01;
      @(negedge clk); tx_pop = 2'b00;
    end
    chk("R13 empty", {27'd0, tx_level_a, tx_full}, 32'd0);
    chk("R13 b untouched", {29'd0, tx_level_b}, 32'd0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule